// File: doc/BRIEF.md
# Partial Reconfiguration Host Register Block

This block is the host-facing side of a partial-reconfiguration engine. A host loads a configuration image into a region of the device through 64-bit register reads and writes. The host first pulses an engine reset and waits for its acknowledge. It then picks a target region, raises a start request and pushes the image one 32-bit word per data-register write. Before each push it reads a credit count that tells it how much room is left in the internal word queue. When the host announces that every word has been pushed, the engine drains the queue into the downstream configuration sink. It then drops the start request on its own, and the host sees the operation return to idle.

Words leave the queue through a valid/ready pair toward a sink model. Faults are collected in a sticky error register that the host clears by writing ones to the bits it wants cleared. Checksum and compatibility faults are not computed here; they arrive on two pulse inputs. A 128-bit compatibility identifier, fixed by parameters, can be read as two 64-bit halves.

Top module: `recfg_host_regs`

## Requirements
- R1: Registers sit at byte offsets control 0x08, status 0x10, data 0x18, error 0x20, identifier high 0xA8 and identifier low 0xB0. The identifier halves return the parameters ID_HI and ID_LO, and writes to them change nothing. The data offset and every unmapped offset read as zero.
- R2: Control bit 0 is the host's reset request and control bit 4 is its acknowledge. Bit 4 reads 1 from the cycle after bit 0 is written to 1, and reads 0 from the cycle after bit 0 is written back to 0. While bit 0 is held, the queue is emptied, start and completion are cleared, and the credit count equals DEPTH.
- R3: Control bits 9:7 hold the 3-bit target region number. Every control write updates them, and they read back as written.
- R4: Writing 1 to control bit 12 while idle and out of reset sets the start request. Status bit 16 reads 1 while start is set and 0 when idle. Writing 0 to bit 12 does not clear it.
- R5: Status bits 8:0 give the free queue entries, which is DEPTH minus the queued words. Each accepted data write lowers the count by one.
- R6: The low 32 bits of each accepted data write reach the sink in write order. One word moves in each cycle in which both sinkValid and sinkReady are high.
- R7: Control bit 13 is the completion notice, accepted while start is set. Start stays set while any word remains queued. Once the queue is empty, start and bit 13 clear together, status bit 16 returns to 0 and the credits return to DEPTH.
- R8: A data write made while the credit count is zero is dropped and sets error bit 4 (queue overflow).
- R9: A data write made while start is clear, or after completion has been noticed, is dropped and sets error bit 3 (push protocol violation). Writing control bit 13 while start is clear also sets bit 3.
- R10: A start request written while the reset request is held is ignored and sets error bit 0 (operation error).
- R11: A one-cycle pulse on crcErrIn sets error bit 1, and a pulse on incompatErrIn sets error bit 2.
- R12: Error bits are sticky. Writing the error register clears exactly the bits written as 1 and leaves the others alone. A bit being set in the same cycle stays set.
- R13: Status bits 27:24 give the host phase: 0 idle, 1 receiving, 2 draining after completion. Status bits 22:20 give queue full (bit 22), reset acknowledge (bit 21) and sinkValid (bit 20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one write per cycle |
| regAddr | input | ADDR_W | Byte offset of the register being accessed |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Read data for regAddr, combinational |
| crcErrIn | input | 1 | Checksum fault pulse |
| incompatErrIn | input | 1 | Image incompatibility pulse |
| sinkValid | output | 1 | A queued word is offered to the sink |
| sinkReady | input | 1 | Sink takes the offered word |
| sinkData | output | DATA_W | Offered word |

## Verification
The hardest situation to reach is a completed transfer whose start bit must stay set: completion has been noticed, but words are still queued behind a stalled sink. The bench gets there by holding sinkReady low through the whole push and the completion write. It then checks that the busy bit and draining phase persist, and that a late data write is refused as a protocol violation, before it releases the sink. The same stall is used to fill the queue to zero credits so that a push with no credits can be made. Transfer lengths from one word to beyond the queue depth are swept under a ready line held high and under one that toggles every cycle. In every case the delivered words are compared with the pushed sequence.

// File: rtl/recfg_pkg.sv
package recfg_pkg;

  // Register byte offsets (the host driver decodes these)
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_STATUS = 8'h10;
  localparam logic [7:0] OFF_DATA   = 8'h18;
  localparam logic [7:0] OFF_ERR    = 8'h20;
  localparam logic [7:0] OFF_ID_HI  = 8'hA8;
  localparam logic [7:0] OFF_ID_LO  = 8'hB0;

  // Control bit positions
  localparam int CB_RST_REQ  = 0;
  localparam int CB_RST_ACK  = 4;
  localparam int CB_REG_LO   = 7;
  localparam int CB_REG_HI   = 9;
  localparam int CB_START    = 12;
  localparam int CB_COMPLETE = 13;

  // Error bit positions
  localparam int EB_OP   = 0;
  localparam int EB_CRC  = 1;
  localparam int EB_INC  = 2;
  localparam int EB_PROT = 3;
  localparam int EB_OVF  = 4;
  localparam int ERR_W   = 5;

  // Host phase codes reported in status
  typedef enum logic [3:0] {
    PH_IDLE  = 4'd0,
    PH_RECV  = 4'd1,
    PH_DRAIN = 4'd2
  } hostPhase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic flush;
  } dpStrobe_t;

endpackage

// File: rtl/recfg_ctrl.sv
module recfg_ctrl
  import recfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       regWrData,
  input  logic              crcErrIn,
  input  logic              incompatErrIn,
  input  logic              dpFull,
  input  logic              dpEmpty,
  output dpStrobe_t         strobe,
  output logic [63:0]       ctrlImage,
  output logic [63:0]       errImage,
  output logic              busy,
  output logic              rstAckOut,
  output hostPhase_e        phase
);

  logic             rstReq, rstAck, startQ, completeQ;
  logic [2:0]       region;
  logic [ERR_W-1:0] errBits, errSet, errClr;
  logic             ctrlWr, dataWr, errWr, finish;

  assign ctrlWr = regWrEn && (regAddr == ADDR_W'(OFF_CTRL));
  assign dataWr = regWrEn && (regAddr == ADDR_W'(OFF_DATA));
  assign errWr  = regWrEn && (regAddr == ADDR_W'(OFF_ERR));
  assign finish = startQ && completeQ && dpEmpty;

  always_comb begin
    errSet       = '0;
    strobe.push  = 1'b0;
    strobe.flush = rstReq;
    if (dataWr) begin
      if (!startQ || completeQ || rstReq) errSet[EB_PROT] = 1'b1;
      else if (dpFull)                    errSet[EB_OVF]  = 1'b1;
      else                                strobe.push     = 1'b1;
    end
    if (ctrlWr && regWrData[CB_START] && !startQ && rstReq) errSet[EB_OP] = 1'b1;
    if (ctrlWr && regWrData[CB_COMPLETE] && !startQ)        errSet[EB_PROT] = 1'b1;
    if (crcErrIn)      errSet[EB_CRC] = 1'b1;
    if (incompatErrIn) errSet[EB_INC] = 1'b1;
    errClr = errWr ? regWrData[ERR_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq    <= 1'b0;
      rstAck    <= 1'b0;
      startQ    <= 1'b0;
      completeQ <= 1'b0;
      region    <= '0;
      errBits   <= '0;
    end else begin
      rstAck  <= rstReq;
      errBits <= (errBits & ~errClr) | errSet;
      if (ctrlWr) begin
        rstReq <= regWrData[CB_RST_REQ];
        region <= regWrData[CB_REG_HI:CB_REG_LO];
      end
      if (rstReq || finish) begin
        startQ    <= 1'b0;
        completeQ <= 1'b0;
      end else if (ctrlWr) begin
        if (regWrData[CB_START] && !startQ)   startQ    <= 1'b1;
        if (regWrData[CB_COMPLETE] && startQ) completeQ <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrlImage                        = '0;
    ctrlImage[CB_RST_REQ]            = rstReq;
    ctrlImage[CB_RST_ACK]            = rstAck;
    ctrlImage[CB_REG_HI:CB_REG_LO]   = region;
    ctrlImage[CB_START]              = startQ;
    ctrlImage[CB_COMPLETE]           = completeQ;
    errImage                         = '0;
    errImage[ERR_W-1:0]              = errBits;
  end

  assign busy      = startQ;
  assign rstAckOut = rstAck;
  assign phase     = !startQ ? PH_IDLE : (completeQ ? PH_DRAIN : PH_RECV);

  AST_ACK_FLUSHED: assert property (@(posedge clk) disable iff (!rstN)
    rstAck |-> (dpEmpty && !startQ)); // R2

  AST_START_ONLY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startQ) |-> !$past(rstReq)); // R4

  AST_FINISH_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(startQ) && !$past(rstReq)) |-> ($past(completeQ) && $past(dpEmpty))); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(errBits) & ~errBits)) |-> $past(errWr)); // R12

endmodule

// File: rtl/recfg_dpath.sv
module recfg_dpath
  import recfg_pkg::*;
#(
  parameter int          DEPTH  = 8,
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 8,
  parameter logic [63:0] ID_HI  = 64'h0,
  parameter logic [63:0] ID_LO  = 64'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] pushData,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       ctrlImage,
  input  logic [63:0]       errImage,
  input  logic              busy,
  input  logic              rstAck,
  input  hostPhase_e        phase,
  output logic [63:0]       regRdData,
  output logic              dpFull,
  output logic              dpEmpty,
  output logic              sinkValid,
  input  logic              sinkReady,
  output logic [DATA_W-1:0] sinkData
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrPtrNext, rdPtrNext;
  logic [CNT_W-1:0]  count;
  logic              pop;
  logic [8:0]        credits;
  logic [63:0]       statusImage;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : gPow2Wrap
      assign wrPtrNext = wrPtr + 1'b1;
      assign rdPtrNext = rdPtr + 1'b1;
    end else begin : gCmpWrap
      assign wrPtrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdPtrNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  assign dpEmpty   = (count == '0);
  assign dpFull    = (count == CNT_W'(DEPTH));
  assign sinkValid = !dpEmpty;
  assign sinkData  = mem[rdPtr];
  assign pop       = sinkValid && sinkReady && !strobe.flush;

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtrNext;
      if (pop)         rdPtr <= rdPtrNext;
      count <= count + CNT_W'(strobe.push) - CNT_W'(pop);
    end
  end

  assign credits = 9'(DEPTH) - 9'(count);

  always_comb begin
    statusImage        = '0;
    statusImage[8:0]   = credits;
    statusImage[16]    = busy;
    statusImage[20]    = sinkValid;
    statusImage[21]    = rstAck;
    statusImage[22]    = dpFull;
    statusImage[27:24] = phase;
  end

  always_comb begin
    if      (regAddr == ADDR_W'(OFF_CTRL))   regRdData = ctrlImage;
    else if (regAddr == ADDR_W'(OFF_STATUS)) regRdData = statusImage;
    else if (regAddr == ADDR_W'(OFF_ERR))    regRdData = errImage;
    else if (regAddr == ADDR_W'(OFF_ID_HI))  regRdData = ID_HI;
    else if (regAddr == ADDR_W'(OFF_ID_LO))  regRdData = ID_LO;
    else                                     regRdData = '0;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R5

  AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rstN)
    $past(pop && !strobe.push && !strobe.flush) |-> (count == $past(count) - 1'b1)); // R6

endmodule

// File: rtl/recfg_host_regs.sv
module recfg_host_regs
  import recfg_pkg::*;
#(
  parameter int          DEPTH  = 8,
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 8,
  parameter logic [63:0] ID_HI  = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] ID_LO  = 64'hFEDC_BA98_7654_3210
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  input  logic              crcErrIn,
  input  logic              incompatErrIn,
  output logic              sinkValid,
  input  logic              sinkReady,
  output logic [DATA_W-1:0] sinkData
);

  dpStrobe_t   strobe;
  logic [63:0] ctrlImage, errImage;
  logic        busy, rstAck, dpFull, dpEmpty;
  hostPhase_e  phase;

  recfg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .crcErrIn(crcErrIn), .incompatErrIn(incompatErrIn),
    .dpFull(dpFull), .dpEmpty(dpEmpty), .strobe(strobe),
    .ctrlImage(ctrlImage), .errImage(errImage), .busy(busy),
    .rstAckOut(rstAck), .phase(phase)
  );

  recfg_dpath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_HI(ID_HI), .ID_LO(ID_LO)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(regWrData[DATA_W-1:0]),
    .regAddr(regAddr), .ctrlImage(ctrlImage), .errImage(errImage), .busy(busy),
    .rstAck(rstAck), .phase(phase), .regRdData(regRdData), .dpFull(dpFull),
    .dpEmpty(dpEmpty), .sinkValid(sinkValid), .sinkReady(sinkReady), .sinkData(sinkData)
  );

endmodule

// File: tb/sim_recfg_host_regs.sv
module sim_recfg_host_regs;

  localparam int          DEPTH = 4;
  localparam logic [63:0] IDH   = 64'h1122_3344_5566_7788;
  localparam logic [63:0] IDL   = 64'h99AA_BBCC_DDEE_FF00;
  localparam logic [7:0]  A_CTRL = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18,
                          A_ERR = 8'h20, A_IDH = 8'hA8, A_IDL = 8'hB0;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [63:0] regWrData = '0, regRdData;
  logic        crcErrIn = 1'b0, incompatErrIn = 1'b0;
  logic        sinkValid, sinkReady = 1'b0;
  logic [31:0] sinkData;

  int checks = 0, errors = 0, readyMode = 0, cyc = 0, recvCnt = 0;
  logic [31:0] recv [64];
  logic [31:0] expw [64];
  bit done = 0;

  always #4 clk = ~clk;

  recfg_host_regs #(.DEPTH(DEPTH), .ID_HI(IDH), .ID_LO(IDL)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .crcErrIn(crcErrIn),
    .incompatErrIn(incompatErrIn), .sinkValid(sinkValid), .sinkReady(sinkReady),
    .sinkData(sinkData)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (readyMode == 0)      sinkReady = 1'b0;
    else if (readyMode == 1) sinkReady = 1'b1;
    else                     sinkReady = cyc[0];
  end

  always @(negedge clk) begin
    if (rstN && sinkValid && sinkReady && recvCnt < 64) begin
      recv[recvCnt] = sinkData;
      recvCnt = recvCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  function automatic logic [63:0] cw(input int rg, input bit st, input bit cm, input bit rs);
    return (64'(rg & 7) << 7) | (64'(st) << 12) | (64'(cm) << 13) | 64'(rs);
  endfunction

  task automatic waitIdle();
    logic [63:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(A_STAT, s);
      if (!s[16]) break;
      tick(1);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, s;
    int bad;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state and map
    rd(A_CTRL, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(A_STAT, v); chk(v == 64'(DEPTH), "R5 credits at reset", v, 64'(DEPTH));
    rd(A_ERR, v);  chk(v == 0, "R12 err reset", v, 0);
    rd(A_IDH, v);  chk(v == IDH, "R1 id high", v, IDH);
    rd(A_IDL, v);  chk(v == IDL, "R1 id low", v, IDL);
    wr(A_IDH, 64'hDEAD); rd(A_IDH, v); chk(v == IDH, "R1 id read-only", v, IDH);
    rd(A_DATA, v); chk(v == 0, "R1 data reads zero", v, 0);
    rd(8'h40, v);  chk(v == 0, "R1 unmapped zero", v, 0);

    // R3 region
    wr(A_CTRL, cw(5, 0, 0, 0));
    rd(A_CTRL, v); chk(v[9:7] == 3'd5, "R3 region readback", 64'(v[9:7]), 5);

    // R9 data write while idle
    wr(A_DATA, 64'h55);
    rd(A_ERR, v); chk(v == 64'h8, "R9 push while idle", v, 64'h8);
    rd(A_STAT, v); chk(v[8:0] == 9'(DEPTH) && !sinkValid, "R9 dropped", v, 64'(DEPTH));
    // R9 completion notice while idle
    wr(A_ERR, 64'h8);
    rd(A_ERR, v); chk(v == 0, "R12 w1c clears", v, 0);
    wr(A_CTRL, cw(5, 0, 1, 0));
    rd(A_ERR, v); chk(v == 64'h8, "R9 complete while idle", v, 64'h8);
    wr(A_ERR, 64'h0);
    rd(A_ERR, v); chk(v == 64'h8, "R12 zero write keeps", v, 64'h8);
    wr(A_ERR, 64'h8);

    // R11 fault inputs, R12 partial clear
    crcErrIn = 1'b1; tick(1); crcErrIn = 1'b0;
    incompatErrIn = 1'b1; tick(1); incompatErrIn = 1'b0;
    rd(A_ERR, v); chk(v == 64'h6, "R11 crc and incompat", v, 64'h6);
    wr(A_ERR, 64'h2);
    rd(A_ERR, v); chk(v == 64'h4, "R12 partial clear", v, 64'h4);
    // R12 set wins over clear in the same cycle
    regAddr = A_ERR; regWrData = 64'h4; regWrEn = 1'b1; incompatErrIn = 1'b1;
    tick(1); regWrEn = 1'b0; incompatErrIn = 1'b0;
    rd(A_ERR, v); chk(v == 64'h4, "R12 set beats clear", v, 64'h4);
    wr(A_ERR, 64'h1F);

    // R2 reset handshake, R10
    readyMode = 0; tick(1);
    wr(A_CTRL, cw(2, 1, 0, 0));
    wr(A_DATA, 64'hA1); wr(A_DATA, 64'hA2); wr(A_DATA, 64'hA3);
    rd(A_STAT, v); chk(v[8:0] == 9'(DEPTH - 3), "R5 three pushed", 64'(v[8:0]), 64'(DEPTH - 3));
    regAddr = A_CTRL; regWrData = cw(2, 1, 0, 1); regWrEn = 1'b1;
    #1 v = regRdData; chk(v[4] == 1'b0, "R2 ack not yet", v, 0);
    @(posedge clk); #1; regWrEn = 1'b0;
    rd(A_CTRL, v); chk(v[4] == 1'b0 && v[0], "R2 ack one cycle late", v, 64'h1);
    tick(1);
    rd(A_CTRL, v); chk(v[4] && !v[12], "R2 ack and start cleared", v, 64'h11);
    rd(A_STAT, v); chk(v[8:0] == 9'(DEPTH) && !v[16] && v[21] && !sinkValid, "R2 flushed, R13 ack status", v, 64'(DEPTH));
    wr(A_CTRL, cw(2, 1, 0, 1));
    rd(A_ERR, v); chk(v == 64'h1, "R10 start during reset", v, 1);
    rd(A_STAT, v); chk(!v[16], "R10 start ignored", v, 0);
    wr(A_CTRL, cw(2, 0, 0, 0));
    rd(A_CTRL, v); chk(v[4] == 1'b1, "R2 ack holds one cycle", v, 64'h10);
    tick(1);
    rd(A_CTRL, v); chk(v[4] == 1'b0, "R2 ack released", v, 0);
    wr(A_ERR, 64'h1F);

    // R4, R8, R13: fill with stalled sink, then overflow
    recvCnt = 0;
    wr(A_CTRL, cw(3, 1, 0, 0));
    wr(A_CTRL, cw(3, 0, 0, 0));
    rd(A_STAT, v); chk(v[16] && v[27:24] == 4'd1, "R4 start held, R13 phase recv", v, 64'h0100_0000);
    for (int i = 0; i < DEPTH; i++) begin
      wr(A_DATA, 64'(32'hB000 + i));
      rd(A_STAT, v); chk(v[8:0] == 9'(DEPTH - 1 - i), "R5 credit count", 64'(v[8:0]), 64'(DEPTH - 1 - i));
    end
    rd(A_STAT, v); chk(v[22] && v[20], "R13 full and valid", v, 64'h50_0000);
    wr(A_DATA, 64'hBAD);
    rd(A_ERR, v); chk(v == 64'h10, "R8 overflow flag", v, 64'h10);
    // R7 completion with stalled sink
    wr(A_CTRL, cw(3, 1, 1, 0));
    tick(6);
    rd(A_STAT, v); chk(v[16] && v[27:24] == 4'd2, "R7 start held while queued, R13 drain", v, 64'h0201_0000);
    wr(A_DATA, 64'hBAD2);
    rd(A_ERR, v); chk(v == 64'h18, "R9 push after completion", v, 64'h18);
    readyMode = 1;
    waitIdle();
    rd(A_STAT, v); chk(!v[16] && v[8:0] == 9'(DEPTH) && v[27:24] == 0, "R7 finished and refilled", v, 64'(DEPTH));
    rd(A_CTRL, v); chk(!v[12] && !v[13] && v[9:7] == 3, "R7 start and complete cleared", v, 64'(3 << 7));
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (recv[i] != 32'hB000 + i) bad++;
    chk(recvCnt == DEPTH && bad == 0, "R8 dropped words absent, R6 order", 64'(recvCnt), 64'(DEPTH));
    wr(A_ERR, 64'h1F);

    // R6 sweep: lengths and ready patterns
    for (int mode = 1; mode <= 2; mode++) begin
      for (int len = 1; len <= 9; len++) begin
        readyMode = mode; recvCnt = 0;
        tick(1);
        wr(A_CTRL, cw(len, 1, 0, 0));
        for (int i = 0; i < len; i++) begin
          for (int w = 0; w < 200; w++) begin
            rd(A_STAT, s);
            if (s[8:0] > 1) break;
            tick(1);
          end
          expw[i] = 32'(mode * 4096 + len * 256 + i * 7);
          wr(A_DATA, {32'hFFFF_FFFF, expw[i]});
        end
        wr(A_CTRL, cw(len, 1, 1, 0));
        waitIdle();
        tick(2);
        bad = 0;
        for (int i = 0; i < len; i++) if (recv[i] != expw[i]) bad++;
        chk(recvCnt == len && bad == 0, "R6 sweep order", 64'(recvCnt), 64'(len));
        rd(A_STAT, v); chk(v[8:0] == 9'(DEPTH) && !v[16], "R7 sweep finish", v, 64'(DEPTH));
        rd(A_ERR, v); chk(v == 0, "R9 no spurious error", v, 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule